// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase NCO

This block is the digital core of a direct synthesis oscillator. Every enabled clock cycle it adds a 32-bit tuning word to a phase accumulator. It adds a 12-bit phase offset to the top of the accumulated phase. It then looks up the sine of the resulting 12-bit angle and outputs a 10-bit offset-binary amplitude, ready for an external converter. The output frequency is `tuning_word * f_clk / 2^32`.

The block holds two tuning words and four phase offsets, all supplied on input ports. Each clock, a 1-bit frequency select and a 2-bit phase select pick one of each. The accumulator is never cleared on a switch, so frequency-shift and phase-shift keying can be driven straight from data bits and the waveform stays continuous in phase. A select change or a change of a selected word reaches the output a fixed six cycles later. An active-low sleep input freezes the whole datapath. An asynchronous active-low reset returns it to zero phase and midscale.

Top module: `nco_dual_quad`

## Requirements
- R1: While `rst_ni` is low and in the first four enabled cycles after its release, `sample_o` is 512 (midscale). The tuning and offset ports are not altered by reset.
- R2: On every rising edge with `sleep_ni` high, the 32-bit accumulator adds the tuning word that was selected at the previous enabled edge, modulo 2^32.
- R3: `fsel_i` = 0 selects `ftw0_i` and 1 selects `ftw1_i`. A switch never clears the accumulator, so the phase continues from its current value.
- R4: `psel_i` selects the phase offset, with bit 0 as the LSB: 0 selects `poff0_i`, 1 selects `poff1_i`, 2 selects `poff2_i` and 3 selects `poff3_i`.
- R5: The table angle is the 12 most significant accumulator bits plus the selected offset, modulo 4096. One offset LSB is 2π/4096.
- R6: A value present on `fsel_i`, `psel_i` or a selected word at a rising edge first shows on `sample_o` after the sixth enabled rising edge, counting that edge as the first.
- R7: Pulling `rst_ni` low at any time forces `sample_o` to 512 at once. After release, the phase starts again from zero.
- R8: At a rising edge with `sleep_ni` low, no internal state changes and `sample_o` holds. Once `sleep_ni` is high again, operation continues from the frozen phase.
- R9: For table angle k, `sample_o` = 512 + s·m. Here m = round-half-up(511·sin(2π·r/4096)), with r = k mod 2048, folded to 2048 − r when r > 1024. The sign s is +1 for k < 2048 and −1 otherwise. So k = 0 and k = 2048 give 512, k = 1024 gives 1023, k = 3072 gives 1, and the code is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_ni | input | 1 | Datapath enable; low freezes all state |
| fsel_i | input | 1 | Tuning word select |
| psel_i | input | 2 | Phase offset select |
| ftw0_i | input | 32 | Tuning word 0 |
| ftw1_i | input | 32 | Tuning word 1 |
| poff0_i | input | 12 | Phase offset 0 |
| poff1_i | input | 12 | Phase offset 1 |
| poff2_i | input | 12 | Phase offset 2 |
| poff3_i | input | 12 | Phase offset 3 |
| sample_o | output | 10 | Offset-binary sine amplitude |

## Verification
A scoreboard predicts every enabled output sample under several patterns:
- A coarse tuning word whose steps land exactly on table angles, which exposes accumulator and lookup errors with no truncation involved.
- A fine word with non-zero low bits, which shows whether truncation happens at the right bit.
- Frequency select held and then toggled every few cycles, which separates a continuous-phase switch from one that restarts or mixes up the words.

With a zero tuning word, each offset is selected in turn to pin down the select encoding and the quarter-wave folding at the four cardinal angles. An offset that crosses 4096 checks wrap-around. A select change and a change of a selected word are each timed edge by edge to confirm the six-cycle latency. Sleep is held while the inputs move, and a reset is applied mid-run, to show freezing and restart.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam real PI = 3.14159265358979323846;

  // magnitude of first-quadrant sine sample i, scaled to half the code range
  function automatic int quarter_mag(int unsigned i, int unsigned ph_w, int unsigned amp_w);
    real ang;
    real v;
    ang = 2.0 * PI * real'(i) / real'(1 << ph_w);
    v   = real'((1 << (amp_w - 1)) - 1) * $sin(ang);
    return $rtoi(v + 0.5);
  endfunction
endpackage

// File: rtl/nco_sel_stage.sv
`timescale 1ns/1ps
module nco_sel_stage #(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 12,
  parameter int NUM_FTW = 2,
  parameter int NUM_OFF = 4,
  localparam int FS_W   = $clog2(NUM_FTW),
  localparam int PS_W   = $clog2(NUM_OFF)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              en_i,
  input  logic [FS_W-1:0]                   fsel_i,
  input  logic [PS_W-1:0]                   psel_i,
  input  logic [NUM_FTW-1:0][ACC_W-1:0]     ftw_i,
  input  logic [NUM_OFF-1:0][PH_W-1:0]      off_i,
  output logic [ACC_W-1:0]                  ftw_o,
  output logic [PH_W-1:0]                   off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_o <= '0;
      off_o <= '0;
    end else if (en_i) begin
      ftw_o <= ftw_i[fsel_i];
      off_o <= off_i[psel_i];
    end
  end
endmodule

// File: rtl/nco_phase_accum.sv
`timescale 1ns/1ps
module nco_phase_accum #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  off_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PH_W-1:0]  ph_o
);
  logic [PH_W-1:0] off_d;

  // offset is delayed one stage so both selects see equal latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      off_d <= '0;
      ph_o  <= '0;
    end else if (en_i) begin
      acc_o <= acc_o + ftw_i;
      off_d <= off_i;
      ph_o  <= acc_o[ACC_W-1 -: PH_W] + off_d;
    end
  end
endmodule

// File: rtl/nco_sine_lut.sv
`timescale 1ns/1ps
module nco_sine_lut #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PH_W-1:0]  ph_i,
  output logic [AMP_W-1:0] code_o
);
  import nco_pkg::*;

  localparam int QW = PH_W - 2;
  localparam int QN = 1 << QW;
  localparam int MW = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID  = {1'b1, {MW{1'b0}}};
  localparam logic [QW:0]      QN_V = (QW+1)'(QN);

  logic [MW-1:0] qtab [QN+1];

  for (genvar i = 0; i <= QN; i++) begin : g_q
    localparam logic [MW-1:0] V = MW'(quarter_mag(i, PH_W, AMP_W));
    assign qtab[i] = V;
  end

  logic [1:0]    quad;
  logic [QW-1:0] idx;
  logic [QW:0]   addr;
  logic [MW-1:0] mag_q;
  logic          neg_q;

  assign quad = ph_i[PH_W-1 -: 2];
  assign idx  = ph_i[QW-1:0];
  assign addr = quad[0] ? (QN_V - {1'b0, idx}) : {1'b0, idx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q  <= '0;
      neg_q  <= 1'b0;
      code_o <= MID;
    end else if (en_i) begin
      mag_q  <= qtab[addr];
      neg_q  <= quad[1];
      code_o <= neg_q ? (MID - {1'b0, mag_q}) : (MID + {1'b0, mag_q});
    end
  end
endmodule

// File: rtl/nco_out_delay.sv
`timescale 1ns/1ps
module nco_out_delay #(
  parameter int             W       = 10,
  parameter int             DEPTH   = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_chain
    logic [W-1:0] st [DEPTH];
    for (genvar g = 0; g < DEPTH; g++) begin : g_st
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   st[g] <= RST_VAL;
        else if (en_i) st[g] <= (g == 0) ? d_i : st[(g == 0) ? 0 : g-1];
      end
    end
    assign q_o = st[DEPTH-1];
  end
endmodule

// File: rtl/nco_dual_quad.sv
`timescale 1ns/1ps
module nco_dual_quad #(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 12,
  parameter int AMP_W   = 10,
  parameter int OUT_DLY = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_ni,
  input  logic             fsel_i,
  input  logic [1:0]       psel_i,
  input  logic [ACC_W-1:0] ftw0_i,
  input  logic [ACC_W-1:0] ftw1_i,
  input  logic [PH_W-1:0]  poff0_i,
  input  logic [PH_W-1:0]  poff1_i,
  input  logic [PH_W-1:0]  poff2_i,
  input  logic [PH_W-1:0]  poff3_i,
  output logic [AMP_W-1:0] sample_o
);
  localparam int NUM_FTW = 2;
  localparam int NUM_OFF = 4;
  localparam logic [AMP_W-1:0] MID = {1'b1, {(AMP_W-1){1'b0}}};

  logic                            en;
  logic [NUM_FTW-1:0][ACC_W-1:0]   ftw_arr;
  logic [NUM_OFF-1:0][PH_W-1:0]    off_arr;
  logic [ACC_W-1:0]                ftw_q_w;
  logic [PH_W-1:0]                 off_q_w;
  logic [ACC_W-1:0]                acc_w;
  logic [PH_W-1:0]                 ph_w;
  logic [AMP_W-1:0]                code_w;

  assign en      = sleep_ni;
  assign ftw_arr = {ftw1_i, ftw0_i};
  assign off_arr = {poff3_i, poff2_i, poff1_i, poff0_i};

  nco_sel_stage #(
    .ACC_W(ACC_W), .PH_W(PH_W), .NUM_FTW(NUM_FTW), .NUM_OFF(NUM_OFF)
  ) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .fsel_i(fsel_i), .psel_i(psel_i),
    .ftw_i(ftw_arr), .off_i(off_arr),
    .ftw_o(ftw_q_w), .off_o(off_q_w)
  );

  nco_phase_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .ftw_i(ftw_q_w), .off_i(off_q_w),
    .acc_o(acc_w), .ph_o(ph_w)
  );

  nco_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .ph_i(ph_w), .code_o(code_w)
  );

  nco_out_delay #(.W(AMP_W), .DEPTH(OUT_DLY), .RST_VAL(MID)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .d_i(code_w), .q_o(sample_o)
  );
endmodule

// File: rtl/nco_dual_quad_chk.sv
`timescale 1ns/1ps
module nco_dual_quad_chk #(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 12,
  parameter int AMP_W   = 10,
  parameter int OUT_DLY = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_ni,
  input logic             fsel_i,
  input logic [ACC_W-1:0] ftw0_i,
  input logic [AMP_W-1:0] sample_o,
  input logic [ACC_W-1:0] acc_i,
  input logic [PH_W-1:0]  ph_i
);
  localparam logic [PH_W-1:0]  Q1   = PH_W'(1 << (PH_W-2));
  localparam logic [PH_W-1:0]  Q3   = PH_W'(3 << (PH_W-2));
  localparam logic [AMP_W-1:0] FULL = '1;
  localparam logic [AMP_W-1:0] LOW  = AMP_W'(1);

  AST_FREEZE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ni |=> $stable(acc_i)); // R8

  AST_FREEZE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ni |=> $stable(sample_o)); // R8

  AST_ZERO_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_ni && !fsel_i && ftw0_i == '0) ##1 sleep_ni |=> $stable(acc_i)); // R3

  AST_CODE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != '0); // R9

  if (OUT_DLY == 1) begin : g_lat
    AST_PEAK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_ni && ph_i == Q1) ##1 sleep_ni ##1 sleep_ni |=> sample_o == FULL); // R9

    AST_TROUGH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_ni && ph_i == Q3) ##1 sleep_ni ##1 sleep_ni |=> sample_o == LOW); // R9
  end
endmodule

bind nco_dual_quad nco_dual_quad_chk #(
  .ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .OUT_DLY(OUT_DLY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_ni(sleep_ni), .fsel_i(fsel_i),
  .ftw0_i(ftw0_i), .sample_o(sample_o), .acc_i(acc_w), .ph_i(ph_w)
);

// File: tb/nco_dual_quad_bench.sv
`timescale 1ns/1ps
module nco_dual_quad_bench;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sleep_ni = 1'b1;
  logic        fsel_i = 1'b0;
  logic [1:0]  psel_i = 2'd0;
  logic [31:0] ftw0_i = '0;
  logic [31:0] ftw1_i = '0;
  logic [11:0] poff0_i = '0;
  logic [11:0] poff1_i = '0;
  logic [11:0] poff2_i = '0;
  logic [11:0] poff3_i = '0;
  logic [9:0]  sample_o;

  always #2.5 clk = ~clk;

  nco_dual_quad u_nco_dual_quad (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_ni(sleep_ni), .fsel_i(fsel_i),
    .psel_i(psel_i), .ftw0_i(ftw0_i), .ftw1_i(ftw1_i),
    .poff0_i(poff0_i), .poff1_i(poff1_i), .poff2_i(poff2_i), .poff3_i(poff3_i),
    .sample_o(sample_o)
  );

  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;
  int          exp_q[$];
  logic [31:0] m_acc;
  logic [11:0] m_prev_off;
  logic [9:0]  last_out;
  string       cur_req = "R2";

  function automatic int code_of(logic [11:0] k);
    int r;
    int m;
    r = int'(k) % 2048;
    if (r > 1024) r = 2048 - r;
    m = $rtoi(511.0 * $sin(2.0 * PI * real'(r) / 4096.0) + 0.5);
    return (k >= 12'd2048) ? 512 - m : 512 + m;
  endfunction

  function automatic logic [11:0] sel_off();
    case (psel_i)
      2'd0:    return poff0_i;
      2'd1:    return poff1_i;
      2'd2:    return poff2_i;
      default: return poff3_i;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_init();
    exp_q.delete();
    repeat (4) exp_q.push_back(512);
    m_acc      = '0;
    m_prev_off = '0;
    last_out   = 10'd512;
  endtask

  // driver pushes the prediction for this edge, monitor pops the one due now
  task automatic step();
    logic [11:0] p;
    int e;
    @(posedge clk);
    #1;
    if (sleep_ni) begin
      p = m_acc[31:20] + m_prev_off;
      exp_q.push_back(code_of(p));
      m_acc      = m_acc + (fsel_i ? ftw1_i : ftw0_i);
      m_prev_off = sel_off();
      e = exp_q.pop_front();
      check(int'(sample_o) == e, cur_req, int'(sample_o), e);
    end else begin
      check(sample_o == last_out, "R8", int'(sample_o), int'(last_out));
    end
    last_out = sample_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(sample_o == 10'd512, "R7", int'(sample_o), 512);
    @(negedge clk);
    rst_ni = 1'b1;
    model_init();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state and first cycles after release
    repeat (3) @(posedge clk);
    #1;
    check(sample_o == 10'd512, "R1", int'(sample_o), 512);
    @(negedge clk);
    rst_ni = 1'b1;
    model_init();
    ftw0_i = 32'h1234_5678;
    cur_req = "R1";
    repeat (4) step();

    // R2: coarse then fine tuning words
    cur_req = "R2";
    ftw0_i = 32'h0100_0000;
    repeat (200) step();
    ftw0_i = 32'h0123_4567;
    repeat (100) step();

    // R3: switch to word 1, then toggle every three cycles
    cur_req = "R3";
    ftw1_i = 32'h0300_0000;
    fsel_i = 1'b1;
    repeat (100) step();
    for (int i = 0; i < 20; i++) begin
      fsel_i = ~fsel_i;
      repeat (3) step();
    end

    // R7: reset mid-run restarts phase
    cur_req = "R7";
    do_reset();
    ftw0_i = '0;
    ftw1_i = '0;
    fsel_i = 1'b0;
    repeat (10) step();

    // R4: select encoding with a frozen accumulator
    cur_req = "R4";
    poff0_i = 12'd100;
    poff1_i = 12'd700;
    poff2_i = 12'd1500;
    poff3_i = 12'd3000;
    for (int ps = 0; ps < 4; ps++) begin
      logic [11:0] o;
      psel_i = 2'(ps);
      o = sel_off();
      repeat (8) step();
      check(int'(sample_o) == code_of(o), "R4", int'(sample_o), code_of(o));
    end

    // R9: cardinal angles
    cur_req = "R9";
    poff0_i = 12'd0;
    poff1_i = 12'd1024;
    poff2_i = 12'd2048;
    poff3_i = 12'd3072;
    psel_i = 2'd0; repeat (8) step();
    check(sample_o == 10'd512, "R9", int'(sample_o), 512);
    psel_i = 2'd1; repeat (8) step();
    check(sample_o == 10'd1023, "R9", int'(sample_o), 1023);
    psel_i = 2'd2; repeat (8) step();
    check(sample_o == 10'd512, "R9", int'(sample_o), 512);
    psel_i = 2'd3; repeat (8) step();
    check(sample_o == 10'd1, "R9", int'(sample_o), 1);

    // R6: latency of a select change, then of a selected word change
    cur_req = "R6";
    psel_i = 2'd0;
    repeat (8) step();
    psel_i = 2'd1;
    for (int k = 1; k <= 6; k++) begin
      step();
      check(sample_o == ((k < 6) ? 10'd512 : 10'd1023), "R6", int'(sample_o), (k < 6) ? 512 : 1023);
    end
    poff1_i = 12'd3072;
    for (int k = 1; k <= 6; k++) begin
      step();
      check(sample_o == ((k < 6) ? 10'd1023 : 10'd1), "R6", int'(sample_o), (k < 6) ? 1023 : 1);
    end

    // R5: offset crossing 4096 wraps
    cur_req = "R5";
    do_reset();
    psel_i = 2'd0;
    poff0_i = 12'd200;
    ftw0_i = 32'hFA00_0000;
    step();
    ftw0_i = '0;
    repeat (10) step();
    check(int'(sample_o) == code_of(12'd104), "R5", int'(sample_o), code_of(12'd104));

    // R8: sleep freezes, inputs moved meanwhile, then resume
    cur_req = "R8";
    ftw0_i = 32'h0100_0000;
    repeat (20) step();
    sleep_ni = 1'b0;
    repeat (3) step();
    ftw0_i = 32'h0200_0000;
    psel_i = 2'd2;
    poff2_i = 12'd512;
    repeat (7) step();
    sleep_ni = 1'b1;
    repeat (40) step();

    finish_run();
  end
endmodule